// File: doc/BRIEF.md
# Bulk Endpoint Handshake Controller

This block holds the handshake state for one bulk OUT endpoint and one bulk IN endpoint of a USB device controller. The serial engine reports transaction events to it as single-cycle pulses. The block answers each transaction with ACK, NAK or a data packet, and it gates received bytes into the receive FIFO. A local CPU controls it through a small register port. The serial engine, CRC, PID decoding and the FIFO storage are outside the block.

On the OUT side, one status bit does three jobs: it is the interrupt, it marks the receive FIFO as valid, and it decides the NAK. The decision is made when the OUT token ends, before any data arrives. The bit is set only when an accepted packet ends. A NAKed packet never sets it, so a host that keeps retrying cannot hold the FIFO valid forever.

On the IN side, the CPU queues a packet in one of two ways:
- It writes a byte count and then sets a valid bit.
- It sets an end-of-transfer bit, which sends a packet with no bytes.

A NAK never clears the valid bit, so a CPU write that arrives while a NAK is going out always takes effect. The receive byte stream has no back-pressure. `rx_valid_i` marks a byte on the bus. `rx_wr_valid_o` forwards it in the same cycle with no ready signal, so the FIFO must always accept a write it is given. Transaction timing on the bus cannot be stalled.

Top module: `usb_bulk_hs_ctrl`

## Requirements
- R1: An OUT token end (`out_tok_end_i`) sampled while the receive status bit (INT register, address 3, bit 0) is clear accepts the packet. The following packet end (`out_pkt_end_i`) gives a one-cycle `out_ack_o` in the next cycle and sets the receive status bit.
- R2: An OUT token end sampled while the receive status bit is set NAKs the packet. The packet end gives `out_nak_o` in the next cycle. That packet end does not set the receive status bit, even if the CPU cleared the bit during the packet.
- R3: A received byte (`rx_valid_i`) reaches `rx_wr_valid_o` in the same cycle only between the token end and the packet end of an accepted packet. Bytes of a NAKed packet are dropped.
- R4: Writing 1 to INT bit 0 clears the receive status bit. If an accepted packet ends in the same cycle, the bit ends up set.
- R5: An IN token (`in_tok_i`) sampled while both the IN valid bit (address 1, bit 0) and the end-of-transfer bit (address 0, bit 0) are clear gives `in_nak_o` in the next cycle.
- R6: An IN token sampled with the valid bit set and the end-of-transfer bit clear gives `in_data_o` in the next cycle. `in_len_o` equals the byte count register (address 2).
- R7: An IN token sampled with the end-of-transfer bit set gives `in_data_o` with `in_len_o` = 0.
- R8: A CPU write that sets the IN valid bit takes effect in the same cycle as an IN token or a NAK. The bit stays set afterwards.
- R9: A host ACK (`in_host_ack_i`) that follows a sent data packet clears the valid bit, the end-of-transfer bit and the byte count, and it sets the transmit interrupt (INT bit 1). A CPU set of valid, or a count write, in that same cycle wins over the clear.
- R10: Writing 1 to INT bit 1 clears the transmit interrupt. If a host ACK sets it in the same cycle, the set wins.
- R11: After reset all registers read 0 and all handshake outputs and `irq_o` are low.
- R12: Writing 0 to the valid, end-of-transfer or interrupt bits changes nothing. `irq_o` is high exactly when either interrupt bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| out_tok_end_i | input | 1 | Pulse: OUT token to the endpoint has ended |
| out_pkt_end_i | input | 1 | Pulse: OUT data packet has ended |
| rx_valid_i | input | 1 | A received byte is on rx_data_i |
| rx_data_i | input | DATA_W | Received byte |
| out_ack_o | output | 1 | Pulse: send ACK for the OUT packet |
| out_nak_o | output | 1 | Pulse: send NAK for the OUT packet |
| rx_wr_valid_o | output | 1 | Write the byte into the receive FIFO |
| rx_wr_data_o | output | DATA_W | Byte to write |
| in_tok_i | input | 1 | Pulse: IN token to the endpoint |
| in_host_ack_i | input | 1 | Pulse: host ACKed the IN data packet |
| in_data_o | output | 1 | Pulse: send the IN data packet |
| in_nak_o | output | 1 | Pulse: send NAK for the IN token |
| in_len_o | output | CNT_W | Byte count of the packet sent with in_data_o |
| cpu_we_i | input | 1 | CPU register write strobe |
| cpu_addr_i | input | 2 | Register select: 0 control, 1 IN status, 2 IN count, 3 interrupt |
| cpu_wdata_i | input | CNT_W | CPU write data |
| cpu_rdata_o | output | CNT_W | Read data of the selected register |
| irq_o | output | 1 | Either interrupt bit is set |

## Verification
The checker watches several properties on every cycle:
- ACK and NAK never appear together, and neither do data and NAK.
- Every handshake pulse follows the event that caused it.
- The receive status bit rises only together with an ACK.
- No byte is written while the status bit is set.
- A CPU set of the IN valid bit is never lost.
- A zero-length packet always carries a length of 0.

Some behaviour needs directed scenarios in the bench, because it appears only as register state after a sequence of events:
- A NAKed packet does not re-arm the status bit after the CPU clears it mid-packet.
- A set beats a clear when both land in one cycle.
- Writes of zero are ignored.
- The count, valid and end-of-transfer bits return to zero after a host ACK.

// File: rtl/usb_hs_pkg.sv
package usb_hs_pkg;
  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_INSTAT = 2'd1,
    REG_INCNT  = 2'd2,
    REG_INT    = 2'd3
  } reg_sel_e;

  localparam int unsigned BIT_EOT    = 0;
  localparam int unsigned BIT_VALID  = 0;
  localparam int unsigned BIT_RXSTAT = 0;
  localparam int unsigned BIT_TXINT  = 1;
endpackage

// File: rtl/hs_out_ep.sv
module hs_out_ep #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              tok_end_i,
  input  logic              pkt_end_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              stat_clr_i,
  output logic              ack_o,
  output logic              nak_o,
  output logic              wr_valid_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              stat_o
);
  logic in_pkt_q, accept_q, stat_q, ack_q, nak_q;
  logic pkt_done, take_pkt;

  assign pkt_done = pkt_end_i & in_pkt_q;
  assign take_pkt = pkt_done & accept_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      in_pkt_q <= 1'b0;
      accept_q <= 1'b0;
      stat_q   <= 1'b0;
      ack_q    <= 1'b0;
      nak_q    <= 1'b0;
    end else begin
      // decision fixed at token end, before data
      if (tok_end_i) begin
        in_pkt_q <= 1'b1;
        accept_q <= ~stat_q;
      end else if (pkt_end_i) begin
        in_pkt_q <= 1'b0;
      end
      ack_q <= take_pkt;
      nak_q <= pkt_done & ~accept_q;
      // only accepted packets arm the status bit; set beats clear
      if (take_pkt)        stat_q <= 1'b1;
      else if (stat_clr_i) stat_q <= 1'b0;
    end
  end

  assign ack_o      = ack_q;
  assign nak_o      = nak_q;
  assign stat_o     = stat_q;
  assign wr_valid_o = rx_valid_i & in_pkt_q & accept_q;
  assign wr_data_o  = rx_data_i;
endmodule

// File: rtl/hs_in_ep.sv
module hs_in_ep #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             tok_i,
  input  logic             host_ack_i,
  input  logic             valid_set_i,
  input  logic             eot_set_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             tx_clr_i,
  output logic             data_o,
  output logic             nak_o,
  output logic [CNT_W-1:0] len_o,
  output logic             valid_o,
  output logic             eot_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tx_int_o
);
  logic             valid_q, eot_q, pend_q, data_q, nak_q, tx_q;
  logic [CNT_W-1:0] cnt_q, len_q;
  logic             ready, send, done;

  assign ready = valid_q | eot_q;
  assign send  = tok_i & ready;
  assign done  = host_ack_i & pend_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      eot_q   <= 1'b0;
      pend_q  <= 1'b0;
      data_q  <= 1'b0;
      nak_q   <= 1'b0;
      tx_q    <= 1'b0;
      cnt_q   <= '0;
      len_q   <= '0;
    end else begin
      data_q <= send;
      nak_q  <= tok_i & ~ready;
      len_q  <= (send && !eot_q) ? cnt_q : '0;

      if (send)                   pend_q <= 1'b1;
      else if (host_ack_i || tok_i) pend_q <= 1'b0;

      // a NAK never touches the valid bit; CPU set beats ACK clear
      if (valid_set_i) valid_q <= 1'b1;
      else if (done)   valid_q <= 1'b0;

      if (eot_set_i)   eot_q <= 1'b1;
      else if (done)   eot_q <= 1'b0;

      if (cnt_we_i)    cnt_q <= cnt_wdata_i;
      else if (done)   cnt_q <= '0;

      if (done)          tx_q <= 1'b1;
      else if (tx_clr_i) tx_q <= 1'b0;
    end
  end

  assign data_o   = data_q;
  assign nak_o    = nak_q;
  assign len_o    = len_q;
  assign valid_o  = valid_q;
  assign eot_o    = eot_q;
  assign cnt_o    = cnt_q;
  assign tx_int_o = tx_q;
endmodule

// File: rtl/usb_bulk_hs_ctrl.sv
module usb_bulk_hs_ctrl
  import usb_hs_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              out_tok_end_i,
  input  logic              out_pkt_end_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic              out_ack_o,
  output logic              out_nak_o,
  output logic              rx_wr_valid_o,
  output logic [DATA_W-1:0] rx_wr_data_o,
  input  logic              in_tok_i,
  input  logic              in_host_ack_i,
  output logic              in_data_o,
  output logic              in_nak_o,
  output logic [CNT_W-1:0]  in_len_o,
  input  logic              cpu_we_i,
  input  logic [1:0]        cpu_addr_i,
  input  logic [CNT_W-1:0]  cpu_wdata_i,
  output logic [CNT_W-1:0]  cpu_rdata_o,
  output logic              irq_o
);
  reg_sel_e         sel;
  logic             wr_ctrl, wr_instat, wr_int;
  logic             eot_set, valid_set, cnt_we, rx_clr, tx_clr;
  logic             rx_stat, in_valid, in_eot, tx_int;
  logic [CNT_W-1:0] in_cnt;

  assign sel       = reg_sel_e'(cpu_addr_i);
  assign wr_ctrl   = cpu_we_i && (sel == REG_CTRL);
  assign wr_instat = cpu_we_i && (sel == REG_INSTAT);
  assign wr_int    = cpu_we_i && (sel == REG_INT);
  assign eot_set   = wr_ctrl   & cpu_wdata_i[BIT_EOT];
  assign valid_set = wr_instat & cpu_wdata_i[BIT_VALID];
  assign cnt_we    = cpu_we_i && (sel == REG_INCNT);
  assign rx_clr    = wr_int & cpu_wdata_i[BIT_RXSTAT];
  assign tx_clr    = wr_int & cpu_wdata_i[BIT_TXINT];

  hs_out_ep #(.DATA_W(DATA_W)) out_ep_i (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .tok_end_i  (out_tok_end_i),
    .pkt_end_i  (out_pkt_end_i),
    .rx_valid_i (rx_valid_i),
    .rx_data_i  (rx_data_i),
    .stat_clr_i (rx_clr),
    .ack_o      (out_ack_o),
    .nak_o      (out_nak_o),
    .wr_valid_o (rx_wr_valid_o),
    .wr_data_o  (rx_wr_data_o),
    .stat_o     (rx_stat)
  );

  hs_in_ep #(.CNT_W(CNT_W)) in_ep_i (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .tok_i       (in_tok_i),
    .host_ack_i  (in_host_ack_i),
    .valid_set_i (valid_set),
    .eot_set_i   (eot_set),
    .cnt_we_i    (cnt_we),
    .cnt_wdata_i (cpu_wdata_i),
    .tx_clr_i    (tx_clr),
    .data_o      (in_data_o),
    .nak_o       (in_nak_o),
    .len_o       (in_len_o),
    .valid_o     (in_valid),
    .eot_o       (in_eot),
    .cnt_o       (in_cnt),
    .tx_int_o    (tx_int)
  );

  always_comb begin
    cpu_rdata_o = '0;
    unique case (sel)
      REG_CTRL:   cpu_rdata_o[BIT_EOT]   = in_eot;
      REG_INSTAT: cpu_rdata_o[BIT_VALID] = in_valid;
      REG_INCNT:  cpu_rdata_o            = in_cnt;
      REG_INT: begin
        cpu_rdata_o[BIT_RXSTAT] = rx_stat;
        cpu_rdata_o[BIT_TXINT]  = tx_int;
      end
      default:    cpu_rdata_o = '0;
    endcase
  end

  assign irq_o = rx_stat | tx_int;
endmodule

// File: rtl/usb_hs_chk.sv
module usb_hs_chk #(
  parameter int unsigned CNT_W = 7
) (
  input logic             clk,
  input logic             rst_ni,
  input logic             out_pkt_end_i,
  input logic             out_ack_o,
  input logic             out_nak_o,
  input logic             rx_wr_valid_o,
  input logic             in_tok_i,
  input logic             in_data_o,
  input logic             in_nak_o,
  input logic [CNT_W-1:0] in_len_o,
  input logic             rx_stat,
  input logic             in_valid,
  input logic             in_eot,
  input logic             valid_set
);
  // R1
  ack_after_end_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    out_ack_o |-> $past(out_pkt_end_i));
  // R2
  out_hs_excl_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !(out_ack_o && out_nak_o));
  // R2
  stat_only_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(rx_stat) |-> out_ack_o);
  // R3
  no_write_when_full_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    rx_wr_valid_o |-> !rx_stat);
  // R5
  in_nak_after_tok_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    in_nak_o |-> $past(in_tok_i));
  // R6
  in_hs_excl_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !(in_data_o && in_nak_o));
  // R7
  zlp_len_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (in_data_o && $past(in_eot)) |-> (in_len_o == '0));
  // R8
  valid_kept_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    valid_set |=> in_valid);
endmodule

bind usb_bulk_hs_ctrl usb_hs_chk #(.CNT_W(CNT_W)) chk_i (
  .clk           (clk),
  .rst_ni        (rst_ni),
  .out_pkt_end_i (out_pkt_end_i),
  .out_ack_o     (out_ack_o),
  .out_nak_o     (out_nak_o),
  .rx_wr_valid_o (rx_wr_valid_o),
  .in_tok_i      (in_tok_i),
  .in_data_o     (in_data_o),
  .in_nak_o      (in_nak_o),
  .in_len_o      (in_len_o),
  .rx_stat       (rx_stat),
  .in_valid      (in_valid),
  .in_eot        (in_eot),
  .valid_set     (valid_set)
);

// File: tb/usb_bulk_hs_ctrl_tb_top.sv
`timescale 1ns/1ps
module usb_bulk_hs_ctrl_tb_top;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned CNT_W  = 7;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic out_tok_end_i = 0, out_pkt_end_i = 0, rx_valid_i = 0;
  logic [DATA_W-1:0] rx_data_i = '0;
  logic out_ack_o, out_nak_o, rx_wr_valid_o;
  logic [DATA_W-1:0] rx_wr_data_o;
  logic in_tok_i = 0, in_host_ack_i = 0;
  logic in_data_o, in_nak_o;
  logic [CNT_W-1:0] in_len_o;
  logic cpu_we_i = 0;
  logic [1:0] cpu_addr_i = '0;
  logic [CNT_W-1:0] cpu_wdata_i = '0;
  logic [CNT_W-1:0] cpu_rdata_o;
  logic irq_o;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  usb_bulk_hs_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_ni(rst_ni),
    .out_tok_end_i(out_tok_end_i), .out_pkt_end_i(out_pkt_end_i),
    .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i),
    .out_ack_o(out_ack_o), .out_nak_o(out_nak_o),
    .rx_wr_valid_o(rx_wr_valid_o), .rx_wr_data_o(rx_wr_data_o),
    .in_tok_i(in_tok_i), .in_host_ack_i(in_host_ack_i),
    .in_data_o(in_data_o), .in_nak_o(in_nak_o), .in_len_o(in_len_o),
    .cpu_we_i(cpu_we_i), .cpu_addr_i(cpu_addr_i), .cpu_wdata_i(cpu_wdata_i),
    .cpu_rdata_o(cpu_rdata_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive at negedge; release and sample at the following negedge
  task automatic step();
    @(negedge clk);
    out_tok_end_i = 0; out_pkt_end_i = 0; rx_valid_i = 0;
    in_tok_i = 0; in_host_ack_i = 0; cpu_we_i = 0;
  endtask

  task automatic set_wr(input logic [1:0] a, input int d);
    cpu_we_i = 1; cpu_addr_i = a; cpu_wdata_i = CNT_W'(d);
  endtask

  task automatic reg_read(input logic [1:0] a, output int v);
    cpu_addr_i = a; #0.5; v = int'(cpu_rdata_o);
  endtask

  task automatic t_reset();
    int v;
    for (int a = 0; a < 4; a++) begin
      reg_read(2'(a), v); chk("R11 reg after reset", v, 0);
    end
    chk("R11 handshake low", int'({out_ack_o, out_nak_o, in_data_o, in_nak_o}), 0);
    chk("R11 irq low", int'(irq_o), 0);
  endtask

  task automatic t_out_accept();
    int v;
    out_tok_end_i = 1; step();
    for (int i = 0; i < 3; i++) begin
      rx_valid_i = 1; rx_data_i = 8'(8'hA0 + i); #0.5;
      chk("R3 byte forwarded", int'(rx_wr_valid_o), 1);
      chk("R3 byte data", int'(rx_wr_data_o), 8'hA0 + i);
      step();
    end
    out_pkt_end_i = 1; step();
    chk("R1 ack", int'(out_ack_o), 1);
    chk("R1 no nak", int'(out_nak_o), 0);
    reg_read(2'd3, v); chk("R1 status set", v & 1, 1);
    chk("R12 irq high", int'(irq_o), 1);
  endtask

  task automatic t_out_nak();
    int v;
    out_tok_end_i = 1; step();
    rx_valid_i = 1; rx_data_i = 8'h55; #0.5;
    chk("R3 nak byte dropped", int'(rx_wr_valid_o), 0);
    step();
    set_wr(2'd3, 1); step();
    reg_read(2'd3, v); chk("R4 w1c clear", v & 1, 0);
    out_pkt_end_i = 1; step();
    chk("R2 nak", int'(out_nak_o), 1);
    chk("R2 no ack", int'(out_ack_o), 0);
    reg_read(2'd3, v); chk("R2 status not rearmed", v & 1, 0);
    chk("R12 irq low", int'(irq_o), 0);
    out_tok_end_i = 1; step();
    out_pkt_end_i = 1; step();
    chk("R1 next packet acked", int'(out_ack_o), 1);
  endtask

  task automatic t_clr_race();
    int v;
    set_wr(2'd3, 1); step();
    out_tok_end_i = 1; step();
    out_pkt_end_i = 1; set_wr(2'd3, 1); step();
    reg_read(2'd3, v); chk("R4 set beats clear", v & 1, 1);
    set_wr(2'd3, 0); step();
    reg_read(2'd3, v); chk("R12 zero write ignored", v & 1, 1);
    set_wr(2'd3, 1); step();
  endtask

  task automatic t_in_basic();
    int v;
    in_tok_i = 1; step();
    chk("R5 nak", int'(in_nak_o), 1);
    chk("R5 no data", int'(in_data_o), 0);
    set_wr(2'd2, 64); step();
    set_wr(2'd1, 1); step();
    set_wr(2'd1, 0); step();
    reg_read(2'd1, v); chk("R12 valid zero write ignored", v, 1);
    in_tok_i = 1; step();
    chk("R6 data", int'(in_data_o), 1);
    chk("R6 len", int'(in_len_o), 64);
    in_host_ack_i = 1; step();
    reg_read(2'd1, v); chk("R9 valid cleared", v, 0);
    reg_read(2'd2, v); chk("R9 count cleared", v, 0);
    reg_read(2'd3, v); chk("R9 tx int set", v & 2, 2);
    set_wr(2'd3, 2); step();
    reg_read(2'd3, v); chk("R10 tx int cleared", v & 2, 0);
  endtask

  task automatic t_zlp();
    int v;
    set_wr(2'd2, 9); step();
    set_wr(2'd0, 1); step();
    in_tok_i = 1; step();
    chk("R7 data", int'(in_data_o), 1);
    chk("R7 zero len", int'(in_len_o), 0);
    in_host_ack_i = 1; set_wr(2'd3, 2); step();
    reg_read(2'd0, v); chk("R9 eot cleared", v, 0);
    reg_read(2'd3, v); chk("R10 set beats clear", v & 2, 2);
    set_wr(2'd3, 2); step();
  endtask

  task automatic t_nak_race();
    int v;
    in_tok_i = 1; set_wr(2'd1, 1); step();
    chk("R8 nak on old state", int'(in_nak_o), 1);
    reg_read(2'd1, v); chk("R8 valid survives tok", v, 1);
    in_tok_i = 1; step();
    chk("R8 data after race", int'(in_data_o), 1);
    in_host_ack_i = 1; set_wr(2'd1, 1); step();
    reg_read(2'd1, v); chk("R9 cpu set beats ack clear", v, 1);
    reg_read(2'd3, v); chk("R9 tx int on ack", v & 2, 2);
    set_wr(2'd3, 2); step();
    in_host_ack_i = 1; step();
    reg_read(2'd3, v); chk("R9 stray ack ignored", v & 2, 0);
    in_tok_i = 1; step();
    in_host_ack_i = 1; step();
    reg_read(2'd1, v); chk("R9 valid cleared at end", v, 0);
    set_wr(2'd3, 2); step();
    in_tok_i = 1; step();
    set_wr(2'd1, 1); #0.5;
    chk("R8 nak cycle", int'(in_nak_o), 1);
    step();
    reg_read(2'd1, v); chk("R8 valid survives nak", v, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_out_accept();
    t_out_nak();
    t_clr_race();
    t_in_basic();
    t_zlp();
    t_nak_race();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule